// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block is a small programmable engine that plays out a short, fixed-order list of DRAM commands during memory training. A typical example is a DDR3 write-leveling pass. Before a run, software loads four subsequence slots through a register-write port. Each slot describes one step: which command to send, how many times to send it, how many idle cycles go between repeats, how long to wait after the step, which data direction the step belongs to, and the address, row-bit count, bank and rank to drive with it.

A start pulse makes the engine walk slot 0, 1, 2 and 3 in turn with no software involvement between steps. It drives a registered command/address bus, holds a two-bit data-direction tag for the duration of each step, and signals the end of the program with a one-cycle done pulse. The slot contents survive the run, so the same program can be started again. A four-step write-leveling program runs back to back on its own: MR1 with leveling enabled, a write-tagged no-op window, a read-tagged alternate no-op window, and MR1 with address bit 12 set to switch the DQ outputs off.

Top module: `train_cmd_seq`

## Requirements
- R1: After a synchronous reset, busy, done and cmd_valid are 0, cmd_code is 00 and data_dir is 00.
- R2: The cycle after an accepted start shows the first issue of slot 0. Slots run strictly in the order 0, 1, 2, 3, and each slot's first issue directly follows the previous slot's last wait cycle, or its last issue if that wait is 0.
- R3: A slot with execution count N issues its command N times (cmd_valid high for one cycle each). A count of 0 behaves as 1.
- R4: Between consecutive issues of one slot there are exactly gap cycles with cmd_valid low. A gap of 0 gives back-to-back issues.
- R5: After a slot's last issue there are exactly wait cycles with cmd_valid low before the next slot begins or done is raised.
- R6: On an issue cycle the outputs carry the slot's command code (00 no-op, 01 mode-register set, 10 alternate no-op), rank-select flag, address, row-bit count, bank and rank. On every other cycle cmd_code, cmd_rank_sel, cmd_addr, cmd_rowbits, cmd_bank and cmd_rank are all zero.
- R7: data_dir shows the slot's direction tag (00 none, 01 write, 10 read) from its first issue through its last wait cycle, and is 00 whenever busy is low.
- R8: busy is high from the first issue until the last wait cycle of slot 3. In the cycle that follows, done is high for exactly one cycle and busy is low.
- R9: A start pulse while busy is high has no effect on the running sequence.
- R10: A register write while busy is high is dropped. Slot contents are kept across runs, so starting again replays an identical output stream.
- R11: A write with wr_en stores wr_data into slot wr_slot. wr_field selects what is written: 0 is control (bits 1:0 command, bit 2 rank-select), 1 is execution count, 2 is gap, 3 is post-slot wait, 4 is direction (bits 1:0), 5 is address, 6 is row-bit count, and 7 is target (bits 2:0 bank, bits 4:3 rank).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| wr_en | input | 1 | Slot register write strobe |
| wr_slot | input | 2 | Slot index for the write |
| wr_field | input | 3 | Field select for the write |
| wr_data | input | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_code | output | 2 | Command code |
| cmd_rank_sel | output | 1 | Rank-select flag of the issued command |
| cmd_addr | output | 16 | Address driven with the command |
| cmd_rowbits | output | 3 | Row-bit count of the issued command |
| cmd_bank | output | 3 | Bank driven with the command |
| cmd_rank | output | 2 | Target rank (chip select) |
| data_dir | output | 2 | Data-direction tag of the current slot |

## Verification
The assertions rely on start and wr_en never being used to change slot contents in the same cycle that a start is accepted, and on reset being held for at least one clock edge. They also rely on command codes and direction tags being written only with their defined encodings, so the zero-when-idle checks mean something. The stimulus drives every input one time unit after a rising edge, keeps writes and starts in separate cycles, and loads only the defined codes. It exercises counts of 0, 1, 2 and 3, gaps of 0 and more, and a final wait of 0, and it injects a stray start and a write while a run is busy.

// File: rtl/train_seq_pkg.sv
package train_seq_pkg;
  parameter int NUM_SLOTS = 4;
  parameter int ADDR_W    = 16;
  parameter int ROW_W     = 3;
  parameter int BANK_W    = 3;
  parameter int RANK_W    = 2;
  parameter int CNT_W     = 8;
  parameter int GAP_W     = 8;
  parameter int WAIT_W    = 16;
  parameter int DATA_W    = 16;

  localparam int SLOT_W  = $clog2(NUM_SLOTS);
  localparam int FIELD_W = 3;
  localparam int TMR_W   = (GAP_W > WAIT_W) ? GAP_W : WAIT_W;

  localparam logic [1:0] CMD_NOP  = 2'b00;
  localparam logic [1:0] DIR_NONE = 2'b00;

  typedef enum logic [FIELD_W-1:0] {
    FLD_CTRL  = 3'd0,
    FLD_COUNT = 3'd1,
    FLD_GAP   = 3'd2,
    FLD_WAIT  = 3'd3,
    FLD_DIR   = 3'd4,
    FLD_ADDR  = 3'd5,
    FLD_ROW   = 3'd6,
    FLD_TGT   = 3'd7
  } field_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_GAP   = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [1:0]        cmd;
    logic              rsel;
    logic [CNT_W-1:0]  count;
    logic [GAP_W-1:0]  gap;
    logic [WAIT_W-1:0] post_wait;
    logic [1:0]        dir;
    logic [ADDR_W-1:0] addr;
    logic [ROW_W-1:0]  rowbits;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
  } slot_t;
endpackage

// File: rtl/train_slot_regs.sv
module train_slot_regs
  import train_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                lock,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [FIELD_W-1:0]  wr_field,
  input  logic [DATA_W-1:0]   wr_data,
  output slot_t               slots [NUM_SLOTS]
);
  // One register bank per slot; writes are dropped while the sequence runs (R10).
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slots[s] <= '0;
      end else if (wr_en && !lock && (wr_slot == SLOT_W'(s))) begin
        case (field_e'(wr_field))
          FLD_CTRL: begin
            slots[s].cmd  <= wr_data[1:0];
            slots[s].rsel <= wr_data[2];
          end
          FLD_COUNT: slots[s].count     <= wr_data[CNT_W-1:0];
          FLD_GAP:   slots[s].gap       <= wr_data[GAP_W-1:0];
          FLD_WAIT:  slots[s].post_wait <= wr_data[WAIT_W-1:0];
          FLD_DIR:   slots[s].dir       <= wr_data[1:0];
          FLD_ADDR:  slots[s].addr      <= wr_data[ADDR_W-1:0];
          FLD_ROW:   slots[s].rowbits   <= wr_data[ROW_W-1:0];
          FLD_TGT: begin
            slots[s].bank <= wr_data[BANK_W-1:0];
            slots[s].rank <= wr_data[BANK_W +: RANK_W];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/train_seq_fsm.sv
module train_seq_fsm
  import train_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  slot_t             slots [NUM_SLOTS],
  output logic              emit,
  output logic [SLOT_W-1:0] emit_slot,
  output logic              finish,
  output logic              busy_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  seq_state_e        st_q, st_n;
  logic [SLOT_W-1:0] slot_q, slot_n, slot_nx;
  logic [CNT_W-1:0]  rep_q, rep_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n;
  slot_t             cur, nxt, first;

  // Remaining repeats after the first issue; a count of 0 acts as 1 (R3).
  function automatic logic [CNT_W-1:0] extra_reps(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  assign slot_nx = slot_q + 1'b1;
  assign cur     = slots[slot_q];
  assign nxt     = slots[slot_nx];
  assign first   = slots[0];

  always_comb begin
    st_n      = st_q;
    slot_n    = slot_q;
    rep_n     = rep_q;
    tmr_n     = tmr_q;
    emit      = 1'b0;
    emit_slot = slot_q;
    finish    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n      = ST_ISSUE;
          slot_n    = '0;
          emit      = 1'b1;
          emit_slot = '0;
          rep_n     = extra_reps(first.count);
        end
      end
      ST_ISSUE: begin
        if (rep_q != '0) begin
          if (cur.gap != '0) begin
            st_n  = ST_GAP;
            tmr_n = TMR_W'(cur.gap) - 1'b1;
          end else begin
            emit  = 1'b1;
            rep_n = rep_q - 1'b1;
          end
        end else if (cur.post_wait != '0) begin
          st_n  = ST_WAIT;
          tmr_n = TMR_W'(cur.post_wait) - 1'b1;
        end else if (slot_q == LAST_SLOT) begin
          st_n   = ST_IDLE;
          finish = 1'b1;
        end else begin
          slot_n    = slot_nx;
          emit      = 1'b1;
          emit_slot = slot_nx;
          rep_n     = extra_reps(nxt.count);
        end
      end
      ST_GAP: begin
        if (tmr_q != '0) begin
          tmr_n = tmr_q - 1'b1;
        end else begin
          st_n  = ST_ISSUE;
          emit  = 1'b1;
          rep_n = rep_q - 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_q != '0) begin
          tmr_n = tmr_q - 1'b1;
        end else if (slot_q == LAST_SLOT) begin
          st_n   = ST_IDLE;
          finish = 1'b1;
        end else begin
          st_n      = ST_ISSUE;
          slot_n    = slot_nx;
          emit      = 1'b1;
          emit_slot = slot_nx;
          rep_n     = extra_reps(nxt.count);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      rep_q  <= '0;
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      slot_q <= slot_n;
      rep_q  <= rep_n;
      tmr_q  <= tmr_n;
      busy_q <= (st_n != ST_IDLE);
    end
  end
endmodule

// File: rtl/train_cmd_drive.sv
module train_cmd_drive
  import train_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [SLOT_W-1:0] emit_slot,
  input  logic              finish,
  input  slot_t             slots [NUM_SLOTS],
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic              cmd_rank_sel,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ROW_W-1:0]  cmd_rowbits,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [RANK_W-1:0] cmd_rank,
  output logic [1:0]        data_dir,
  output logic              done
);
  slot_t sel;
  assign sel = slots[emit_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid    <= 1'b0;
      cmd_code     <= CMD_NOP;
      cmd_rank_sel <= 1'b0;
      cmd_addr     <= '0;
      cmd_rowbits  <= '0;
      cmd_bank     <= '0;
      cmd_rank     <= '0;
      data_dir     <= DIR_NONE;
      done         <= 1'b0;
    end else begin
      cmd_valid    <= emit;
      cmd_code     <= emit ? sel.cmd     : CMD_NOP;
      cmd_rank_sel <= emit && sel.rsel;
      cmd_addr     <= emit ? sel.addr    : '0;
      cmd_rowbits  <= emit ? sel.rowbits : '0;
      cmd_bank     <= emit ? sel.bank    : '0;
      cmd_rank     <= emit ? sel.rank    : '0;
      done         <= finish;
      if (finish)    data_dir <= DIR_NONE;
      else if (emit) data_dir <= sel.dir;
    end
  end
endmodule

// File: rtl/train_cmd_seq.sv
module train_cmd_seq
  import train_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [FIELD_W-1:0]  wr_field,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                busy,
  output logic                done,
  output logic                cmd_valid,
  output logic [1:0]          cmd_code,
  output logic                cmd_rank_sel,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [ROW_W-1:0]    cmd_rowbits,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [RANK_W-1:0]   cmd_rank,
  output logic [1:0]          data_dir
);
  slot_t             slots [NUM_SLOTS];
  logic              emit, finish, busy_q;
  logic [SLOT_W-1:0] emit_slot;

  assign busy = busy_q;

  train_slot_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .lock     (busy_q),
    .wr_slot  (wr_slot),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .slots    (slots)
  );

  train_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .slots     (slots),
    .emit      (emit),
    .emit_slot (emit_slot),
    .finish    (finish),
    .busy_q    (busy_q)
  );

  train_cmd_drive u_drive (
    .clk          (clk),
    .rst          (rst),
    .emit         (emit),
    .emit_slot    (emit_slot),
    .finish       (finish),
    .slots        (slots),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .cmd_rank_sel (cmd_rank_sel),
    .cmd_addr     (cmd_addr),
    .cmd_rowbits  (cmd_rowbits),
    .cmd_bank     (cmd_bank),
    .cmd_rank     (cmd_rank),
    .data_dir     (data_dir),
    .done         (done)
  );
endmodule

// File: rtl/train_seq_chk.sv
module train_seq_chk
  import train_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        data_dir
);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_end_marked_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_issue_busy_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> (cmd_code == CMD_NOP && cmd_addr == '0));

  assert_dir_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (data_dir == DIR_NONE));

  assert_dir_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmd_valid && $past(busy)) |-> $stable(data_dir));
endmodule

bind train_cmd_seq train_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_addr  (cmd_addr),
  .data_dir  (data_dir)
);

// File: tb/tb_train_cmd_seq.sv
module tb_train_cmd_seq;
  import train_seq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wr_en = 1'b0;
  logic [SLOT_W-1:0]  wr_slot = '0;
  logic [FIELD_W-1:0] wr_field = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic busy, done, cmd_valid, cmd_rank_sel;
  logic [1:0] cmd_code, data_dir;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ROW_W-1:0]  cmd_rowbits;
  logic [BANK_W-1:0] cmd_bank;
  logic [RANK_W-1:0] cmd_rank;

  always #4 clk = ~clk;  // 125 MHz

  train_cmd_seq dut (.*);

  typedef struct packed {
    logic busy, done, valid;
    logic [1:0] code;
    logic rsel;
    logic [ADDR_W-1:0] addr;
    logic [ROW_W-1:0] row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [1:0] dir;
  } rec_t;

  rec_t exp_q[$];
  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;

  // Behavioural copy of the program (only what software wrote)
  int m_cmd[4], m_rsel[4], m_cnt[4], m_gap[4], m_wait[4], m_dir[4];
  int m_addr[4], m_row[4], m_bank[4], m_rank[4];

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    report();
  end

  function automatic rec_t idle_rec();
    rec_t r = '0;
    return r;
  endfunction

  // Build the expected per-cycle stream (R2..R8)
  task automatic build_stream();
    for (int s = 0; s < 4; s++) begin
      int n = (m_cnt[s] == 0) ? 1 : m_cnt[s];
      rec_t idle_b = '0;
      idle_b.busy = 1'b1;
      idle_b.dir  = 2'(m_dir[s]);
      for (int i = 0; i < n; i++) begin
        rec_t r = idle_b;
        r.valid = 1'b1;
        r.code  = 2'(m_cmd[s]);
        r.rsel  = 1'(m_rsel[s]);
        r.addr  = ADDR_W'(m_addr[s]);
        r.row   = ROW_W'(m_row[s]);
        r.bank  = BANK_W'(m_bank[s]);
        r.rank  = RANK_W'(m_rank[s]);
        exp_q.push_back(r);
        if (i < n - 1) for (int g = 0; g < m_gap[s]; g++) exp_q.push_back(idle_b);
      end
      for (int w = 0; w < m_wait[s]; w++) exp_q.push_back(idle_b);
    end
    begin
      rec_t d = '0;
      d.done = 1'b1;
      exp_q.push_back(d);
    end
  endtask

  task automatic fcheck(input string tag, input string name, input longint act,
                        input longint exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, name, act, exp, $time);
      bad = 1'b1;
    end
  endtask

  task automatic compare(input rec_t e, input string rtag);
    bit bad = 1'b0;
    checks++;
    fcheck(rtag == "" ? "R8" : rtag, "busy", busy, e.busy, bad);
    fcheck(rtag == "" ? "R8" : rtag, "done", done, e.done, bad);
    fcheck(rtag == "" ? "R2/R3/R4/R5" : rtag, "cmd_valid", cmd_valid, e.valid, bad);
    fcheck(rtag == "" ? "R6" : rtag, "cmd_code", cmd_code, e.code, bad);
    fcheck(rtag == "" ? "R6" : rtag, "cmd_rank_sel", cmd_rank_sel, e.rsel, bad);
    fcheck(rtag == "" ? "R6" : rtag, "cmd_addr", cmd_addr, e.addr, bad);
    fcheck(rtag == "" ? "R6" : rtag, "cmd_rowbits", cmd_rowbits, e.row, bad);
    fcheck(rtag == "" ? "R6" : rtag, "cmd_bank", cmd_bank, e.bank, bad);
    fcheck(rtag == "" ? "R6" : rtag, "cmd_rank", cmd_rank, e.rank, bad);
    fcheck(rtag == "" ? "R7" : rtag, "data_dir", data_dir, e.dir, bad);
    if (bad) fails++;
  endtask

  // Reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      rec_t e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_rec();
      compare(e, "");
    end
  end

  // R11: field map of the write port; blocked writes leave the model unchanged (R10)
  task automatic wr(input int slot, input int field, input int data, input bit blocked);
    wr_en = 1'b1; wr_slot = SLOT_W'(slot); wr_field = FIELD_W'(field); wr_data = DATA_W'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (!blocked) begin
      case (field)
        0: begin m_cmd[slot] = data & 3; m_rsel[slot] = (data >> 2) & 1; end
        1: m_cnt[slot]  = data & 8'hFF;
        2: m_gap[slot]  = data & 8'hFF;
        3: m_wait[slot] = data & 16'hFFFF;
        4: m_dir[slot]  = data & 3;
        5: m_addr[slot] = data & 16'hFFFF;
        6: m_row[slot]  = data & 7;
        7: begin m_bank[slot] = data & 7; m_rank[slot] = (data >> 3) & 3; end
        default: ;
      endcase
    end
  endtask

  task automatic load_slot(input int s, input int cmd, input int rsel, input int cnt,
                           input int gap, input int wt, input int dir, input int addr,
                           input int row, input int bank, input int rank);
    wr(s, 0, (rsel << 2) | cmd, 1'b0);
    wr(s, 1, cnt, 1'b0);
    wr(s, 2, gap, 1'b0);
    wr(s, 3, wt, 1'b0);
    wr(s, 4, dir, 1'b0);
    wr(s, 5, addr, 1'b0);
    wr(s, 6, row, 1'b0);
    wr(s, 7, (rank << 3) | bank, 1'b0);
  endtask

  task automatic kick();
    start = 1'b1;
    @(posedge clk);
    build_stream();
    #1 start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    int cwl, twlo, cas, tmod, mr1;
    for (int s = 0; s < 4; s++) begin
      m_cmd[s] = 0; m_rsel[s] = 0; m_cnt[s] = 0; m_gap[s] = 0; m_wait[s] = 0;
      m_dir[s] = 0; m_addr[s] = 0; m_row[s] = 0; m_bank[s] = 0; m_rank[s] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    compare(idle_rec(), "R1");  // reset state
    cmp_en = 1'b1;
    @(posedge clk); #1;

    // Write-leveling program (R2, R3, R5, R6, R7, R8)
    cwl = 5; twlo = 7; cas = 6; tmod = 12; mr1 = 16'h00C4;
    load_slot(0, 1, 1, 1, 3, 40,       0, mr1,            6, 1, 1);
    load_slot(1, 0, 1, 1, 3, cwl+twlo, 1, 8,              0, 0, 1);
    load_slot(2, 2, 1, 1, 3, cas+38,   2, 4,              0, 0, 1);
    load_slot(3, 1, 1, 1, 3, tmod,     0, mr1 | (1 << 12), 6, 1, 1);
    kick();
    drain();

    // Repeats, gaps, count 0, zero wait at end (R3, R4, R5)
    load_slot(0, 1, 0, 3, 2, 4, 1, 16'h1234, 5, 2, 3);
    load_slot(1, 2, 1, 0, 5, 0, 2, 16'h00FF, 1, 7, 0);
    load_slot(2, 0, 0, 2, 0, 1, 0, 16'hABCD, 7, 0, 1);
    load_slot(3, 1, 1, 1, 9, 0, 2, 16'h8001, 2, 4, 2);
    kick();
    drain();

    // R9: stray start mid-run; R10: write mid-run is dropped
    wr(0, 3, 30, 1'b0);
    kick();
    repeat (6) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wr(2, 5, 16'h5555, 1'b1);
    wr(1, 1, 7, 1'b1);
    drain();

    // R10: rerun replays the same program
    kick();
    drain();

    cmp_en = 1'b0;
    report();
  end
endmodule